// File: doc/BRIEF.md
# Cyclic User-Bit Ring Serializer

This block keeps eight byte-wide locations that a host reaches through an 8-bit parallel data bus with a 5-bit address. Location 0 is a read-only status byte, locations 1 to 3 are control bytes, and locations 4 to 7 form a four-byte ring of user data. A second, internal read port walks the ring in a fixed cycle. It drops each byte into an 8-bit shift register, which supplies one user bit to a downstream frame encoder for every single-channel audio sample.

A one-cycle `sample_tick` pulse marks each sample. On the first tick of a byte, the location under the internal pointer is copied into the shift register. Its D0 goes out at once, and the other bits follow, one per tick, LSB first. After eight ticks the pointer moves to the next location. After 32 ticks it returns to location 4. Each copy marks its location as free in the status byte, and the host is told through an active-low interrupt. The host can then refill that location while the other bytes are still being sent.

Top module: `user_bit_ring`

## Requirements
- R1: After a synchronous active-low reset, all locations read 0, `user_bit` is 0 and `irq_n` is 1. The first byte loaded for output is the one at location 4.
- R2: Host writes to locations 1 to 7 are stored and read back unchanged. Writes to location 0 (status) have no effect.
- R3: Each `sample_tick` puts out one bit of the current byte, LSB (D0) first, on `user_bit` in the cycle after the tick. Without a tick, `user_bit` holds its value.
- R4: The bytes go out whole, in the order of locations 4, 5, 6, 7. Eight ticks are spent on each byte.
- R5: After 32 ticks the pointer wraps, so the 33rd tick loads location 4 again, including any value the host wrote there in the meantime.
- R6: Each byte load sets status bit 7 and writes the location just loaded (4 to 7) into status bits 2:0.
- R7: `irq_n` is 0 exactly while status bit 7 is set and control location 1 bit 0 (interrupt enable) is 1. Otherwise it is 1.
- R8: A host read of location 0 clears status bit 7 and leaves bits 2:0 unchanged. If a byte load happens in the same cycle, bit 7 stays set.
- R9: If the host writes the location being loaded in the same cycle as the load, the shift register receives the value stored before the write. The location then holds the newly written value.
- R10: Reads at addresses 8 to 31 return 0. Writes there change no location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Host access strobe for this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Host location address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| sample_tick | input | 1 | One pulse per single-channel audio sample |
| user_bit | output | 1 | Serial user bit to the frame encoder |
| irq_n | output | 1 | Active-low byte-freed interrupt |

## Verification
The hardest situations to create are the two same-cycle collisions between the host port and the internal load. One is a status read that coincides with a load. The other is a write to the very location being loaded. To reach them, the bench tracks its own sample position and ticks until the next tick is due to start a byte. It then drives that tick together with the host access in a single cycle. It checks the result in two places: on the serial bits that follow, and by reading the location and the status back.

// File: rtl/ubr_pkg.sv
// Shared constants for the user-bit ring: location map and bit positions.
package ubr_pkg;
    localparam int RING_BYTES = 4;            // user-data locations in the ring
    localparam int RING_BASE  = 4;            // first ring location
    localparam int LOCS       = RING_BASE + RING_BYTES;
    localparam int LOC_W      = $clog2(LOCS);
    localparam int IDX_W      = $clog2(RING_BYTES);
    localparam int LOC_STATUS = 0;
    localparam int LOC_CTRL   = 1;
    localparam int FLAG_BIT   = 7;            // status: byte freed
    localparam int IEN_BIT    = 0;            // control: interrupt enable
endpackage

// File: rtl/ubr_hostregs.sv
// Host-side location file: status byte, control bytes and the user ring.
// Assumes the host access is single-cycle and DATA_W is at least 8.
// The ring has a second read port (ring_idx -> ring_byte) for the serializer.
module ubr_hostregs
    import ubr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  ring_idx,
    output logic [DATA_W-1:0] ring_byte,
    input  logic              load_evt,
    input  logic [IDX_W-1:0]  load_idx,
    output logic              freed_flag,
    output logic              irq_en
);
    logic              in_range;
    logic [LOC_W-1:0]  loc;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] ring_q [RING_BYTES];
    logic [DATA_W-1:0] cfg_q  [1:RING_BASE-1];
    logic              flag_q;
    logic [LOC_W-1:0]  frd_q;

    // Decode the host address into a local location and access strobes.
    always_comb begin
        in_range = (host_addr < ADDR_W'(LOCS));
        loc      = host_addr[LOC_W-1:0];
        wr_en    = host_cs && host_we && in_range;
        rd_en    = host_cs && !host_we && in_range;
    end

    // One storage register per ring location, written only by the host.
    for (genvar g = 0; g < RING_BYTES; g++) begin : g_ring
        always_ff @(posedge clk) begin
            if (!rst_n)
                ring_q[g] <= '0;
            else if (wr_en && loc == LOC_W'(RING_BASE + g))
                ring_q[g] <= host_wdata;
        end
    end

    // Control bytes between status and the ring.
    for (genvar c = 1; c < RING_BASE; c++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[c] <= '0;
            else if (wr_en && loc == LOC_W'(c))
                cfg_q[c] <= host_wdata;
        end
    end

    // Status: a load sets the flag and records the freed location; a status read clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            frd_q  <= '0;
        end else if (load_evt) begin
            flag_q <= 1'b1;
            frd_q  <= LOC_W'(RING_BASE) + LOC_W'(load_idx);
        end else if (rd_en && loc == LOC_W'(LOC_STATUS)) begin
            flag_q <= 1'b0;
        end
    end

    // Host read multiplexer; out-of-range addresses return zero.
    always_comb begin
        host_rdata = '0;
        if (in_range) begin
            if (loc == LOC_W'(LOC_STATUS)) begin
                host_rdata[FLAG_BIT]  = flag_q;
                host_rdata[LOC_W-1:0] = frd_q;
            end else if (loc < LOC_W'(RING_BASE)) begin
                host_rdata = cfg_q[loc];
            end else begin
                host_rdata = ring_q[IDX_W'(loc - LOC_W'(RING_BASE))];
            end
        end
    end

    // Second read port and control outputs.
    assign ring_byte  = ring_q[ring_idx];
    assign freed_flag = flag_q;
    assign irq_en     = cfg_q[LOC_CTRL][IEN_BIT];

    a_r6_flag_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> flag_q && frd_q == LOC_W'(RING_BASE) + LOC_W'($past(load_idx)));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && !host_we && host_addr == '0 && !load_evt) |=> !flag_q);

    a_r10_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_we && host_addr >= ADDR_W'(LOCS)) |=>
            $stable(ring_q[0]) && $stable(cfg_q[LOC_CTRL]));
endmodule

// File: rtl/ubr_shifter.sv
// Internal read side: cyclic ring pointer, bit counter and LSB-first shifter.
// Assumes sample_tick is a single-cycle pulse; the byte under the pointer is
// loaded on the first tick of each byte and its D0 leaves on that same tick.
module ubr_shifter
    import ubr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic [DATA_W-1:0] ring_byte,
    output logic [IDX_W-1:0]  ring_idx,
    output logic              load_evt,
    output logic [IDX_W-1:0]  load_idx,
    output logic              user_bit
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              bit_q;

    // A load happens on the tick that starts a byte.
    assign load_evt = sample_tick && cnt_q == '0;
    assign load_idx = idx_q;
    assign ring_idx = idx_q;
    assign user_bit = bit_q;

    // Advance one bit per tick; at a byte start take the ring byte and step the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            bit_q <= 1'b0;
        end else if (sample_tick) begin
            if (cnt_q == '0) begin
                bit_q <= ring_byte[0];
                sh_q  <= ring_byte >> 1;
                idx_q <= (idx_q == IDX_W'(RING_BYTES - 1)) ? '0 : idx_q + 1'b1;
            end else begin
                bit_q <= sh_q[0];
                sh_q  <= sh_q >> 1;
            end
            cnt_q <= (cnt_q == CNT_W'(DATA_W - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(bit_q));

    a_r5_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && idx_q == IDX_W'(RING_BYTES - 1)) |=> idx_q == '0);
endmodule

// File: rtl/user_bit_ring.sv
// Top of the user-bit ring serializer: host location file plus cyclic
// LSB-first shifter, with an active-low byte-freed interrupt.
// Assumes one clock domain for host and sample tick.
module user_bit_ring
    import ubr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sample_tick,
    output logic              user_bit,
    output logic              irq_n
);
    logic [IDX_W-1:0]  ring_idx;
    logic [DATA_W-1:0] ring_byte;
    logic              load_evt;
    logic [IDX_W-1:0]  load_idx;
    logic              freed_flag;
    logic              irq_en;

    ubr_hostregs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cs    (host_cs),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ring_idx   (ring_idx),
        .ring_byte  (ring_byte),
        .load_evt   (load_evt),
        .load_idx   (load_idx),
        .freed_flag (freed_flag),
        .irq_en     (irq_en)
    );

    ubr_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .ring_byte   (ring_byte),
        .ring_idx    (ring_idx),
        .load_evt    (load_evt),
        .load_idx    (load_idx),
        .user_bit    (user_bit)
    );

    // Interrupt is driven low while a freed byte is pending and enabled.
    assign irq_n = !(freed_flag && irq_en);

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> irq_en && freed_flag);
endmodule

// File: tb/user_bit_ring_test.sv
module user_bit_ring_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0;
    logic       host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       sample_tick = 1'b0;
    logic       user_bit;
    logic       irq_n;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] bm [4];   // bench model of ring contents
    logic [7:0] cur;      // byte currently being sent (model)
    int pos = 0;          // sample position within 32

    always #4 clk = ~clk; // 125 MHz

    user_bit_ring uut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sample_tick(sample_tick), .user_bit(user_bit), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    task automatic hwrite(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_we = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_cs = 1'b0;
    endtask

    // One sample tick, optionally with a same-cycle host write to a ring slot or status read.
    task automatic do_tick(input bit wr, input int widx, input logic [7:0] wd, input bit rd_stat);
        logic exp;
        @(negedge clk);
        sample_tick = 1'b1;
        host_cs = wr | rd_stat; host_we = wr;
        host_addr = wr ? 5'(4 + widx) : 5'd0; host_wdata = wd;
        if (pos % 8 == 0) cur = bm[pos / 8];
        exp = cur[pos % 8];
        if (wr) bm[widx] = wd;
        pos = (pos + 1) % 32;
        @(negedge clk);
        sample_tick = 1'b0; host_cs = 1'b0; host_we = 1'b0;
        chk($sformatf("R3/R4 bit at pos %0d", (pos + 31) % 32), {7'd0, user_bit}, {7'd0, exp});
    endtask

    task automatic tick_to_byte_start();
        while (pos % 8 != 0) do_tick(0, 0, 8'h00, 0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 user_bit", {7'd0, user_bit}, 8'h00);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        for (int a = 0; a < 8; a++) begin
            hread(5'(a), d);
            chk($sformatf("R1 loc %0d", a), d, 8'h00);
        end
    endtask

    task automatic t_host_access();
        logic [7:0] d;
        for (int a = 1; a < 8; a++) hwrite(5'(a), 8'(8'h11 * a + 8'h20));
        for (int a = 1; a < 8; a++) begin
            hread(5'(a), d);
            chk($sformatf("R2 loc %0d readback", a), d, 8'(8'h11 * a + 8'h20));
        end
        hwrite(5'd0, 8'hFF);
        hread(5'd0, d);
        chk("R2 status not writable", d, 8'h00);
        hwrite(5'd1, 8'h00);
    endtask

    task automatic t_out_of_range();
        logic [7:0] d;
        hwrite(5'd12, 8'h5A);
        hwrite(5'd9, 8'h5A);
        hread(5'd12, d);
        chk("R10 read addr 12", d, 8'h00);
        hread(5'd31, d);
        chk("R10 read addr 31", d, 8'h00);
        hread(5'd4, d);
        chk("R10 loc 4 unchanged", d, bm[0]);
        hread(5'd1, d);
        chk("R10 loc 1 unchanged", d, 8'h00);
    endtask

    task automatic t_stream();
        logic [7:0] d;
        logic held;
        bm[0] = 8'hA5; bm[1] = 8'h3C; bm[2] = 8'h0F; bm[3] = 8'h81;
        for (int i = 0; i < 4; i++) hwrite(5'(4 + i), bm[i]);
        for (int k = 0; k < 32; k++) begin
            do_tick(0, 0, 8'h00, 0);
            if (k % 8 == 0) begin
                hread(5'd0, d);
                chk("R6 status after load", d, 8'(8'h80 | (4 + k / 8)));
                hread(5'd0, d);
                chk("R8 status after read", d, 8'(4 + k / 8));
            end
            if (k == 5) begin
                held = user_bit;
                repeat (3) @(negedge clk);
                chk("R3 hold without tick", {7'd0, user_bit}, {7'd0, held});
            end
        end
        hwrite(5'd4, 8'h6E);
        bm[0] = 8'h6E;
        for (int k = 0; k < 8; k++) do_tick(0, 0, 8'h00, 0);
        hread(5'd0, d);
        chk("R5 wrap reloads loc 4", d, 8'h84);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        tick_to_byte_start();
        hread(5'd0, d);
        hwrite(5'd1, 8'h01);
        chk("R7 irq idle", {7'd0, irq_n}, 8'h01);
        do_tick(0, 0, 8'h00, 0);
        chk("R7 irq asserted", {7'd0, irq_n}, 8'h00);
        hread(5'd0, d);
        chk("R7 irq released after status read", {7'd0, irq_n}, 8'h01);
        hwrite(5'd1, 8'h00);
        tick_to_byte_start();
        do_tick(0, 0, 8'h00, 0);
        chk("R7 irq masked", {7'd0, irq_n}, 8'h01);
        hread(5'd0, d);
        chk("R7 flag set while masked", d[7:0] & 8'h80, 8'h80);
    endtask

    task automatic t_races();
        logic [7:0] d;
        int slot;
        tick_to_byte_start();
        slot = pos / 8;
        do_tick(0, 0, 8'h00, 1);
        hread(5'd0, d);
        chk("R8 load wins over same-cycle read", d, 8'(8'h80 | (4 + slot)));
        tick_to_byte_start();
        slot = pos / 8;
        bm[slot] = 8'h96;
        hwrite(5'(4 + slot), 8'h96);
        do_tick(1, slot, 8'h5B, 0);
        for (int k = 0; k < 7; k++) do_tick(0, 0, 8'h00, 0);
        hread(5'(4 + slot), d);
        chk("R9 new value stored", d, 8'h5B);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        bm[0] = 0; bm[1] = 0; bm[2] = 0; bm[3] = 0; cur = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host_access();
        t_stream();
        t_out_of_range();
        t_irq();
        t_races();
        summary();
        $finish;
    end
endmodule